// File: doc/BRIEF.md
# Iterative Shift-Add Multiplier

This block multiplies two operands one multiplier bit per clock. A start pulse captures both operands. The block then runs one iteration per cycle, for as many cycles as the operand is wide. Each iteration tests the low multiplier bit, adds the multiplicand into the running product when that bit is set, shifts the multiplicand left and shifts the multiplier right. All of this happens in the same clock.

The product is twice the operand width. It is presented as separate high and low words, together with a one-cycle done pulse. With signed operation enabled and requested, the block multiplies operand magnitudes and negates the final product when the operand signs differ. A start that arrives while an operation is running is dropped.

Top module: `shiftadd_mul`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy_o` and `done_o` are 0 and both product words are 0.
- R2: With `signed_i` = 0, `{prod_hi_o, prod_lo_o}` equals the unsigned product of `mcand_i` and `mplier_i`. `prod_hi_o` carries bits 2W-1..W and `prod_lo_o` carries bits W-1..0.
- R3: A start is accepted when `start_i` is 1 at a rising edge where `busy_o` is 0. `busy_o` is 1 from the next cycle for W cycles. `done_o` rises exactly W cycles after the accepting edge.
- R4: `done_o` is high for exactly one cycle, and `busy_o` is 0 in that cycle.
- R5: A start while `busy_o` is 1, including the final iteration cycle, is ignored: it changes neither the timing nor the result of the running operation. A start in the done cycle is accepted.
- R6: With SIGNED_EN = 1 and `signed_i` = 1 at acceptance, the result is the two's complement product of the operands, including for the most negative value.
- R7: Between done pulses, the product words stay unchanged.
- R8: Operands 0, 1 and all-ones give the exact product in both modes.
- R9: At W = 4, the product 2 × 3 yields 6, with done rising 4 cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request |
| signed_i | input | 1 | Treat operands as two's complement (used when SIGNED_EN = 1) |
| mcand_i | input | W | Multiplicand |
| mplier_i | input | W | Multiplier |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle completion pulse |
| prod_hi_o | output | W | Upper word of the product |
| prod_lo_o | output | W | Lower word of the product |

## Verification
Completion and a new request can fall close together in two ways. A start on the final iteration cycle, while `busy_o` is still high, must be dropped. A start in the done cycle must be accepted, so that the next operation runs back to back. The bench issues both kinds of start exactly W−1 and W cycles after an accepted start. A behavioural reference model then judges every cycle: it predicts `busy_o`, `done_o` and both product words, and computes the product with a native wide multiply.

// File: rtl/mul_pkg.sv
package mul_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } mul_state_e;
endpackage

// File: rtl/mul_operand_mag.sv
module mul_operand_mag #(
   parameter int W         = 32,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sgn_i,
   output logic [W-1:0] a_mag_o,
   output logic [W-1:0] b_mag_o,
   output logic         neg_o
);
   generate
      if (SIGNED_EN) begin : g_signed
         logic a_neg, b_neg;
         always_comb begin
            a_neg   = sgn_i & a_i[W-1];
            b_neg   = sgn_i & b_i[W-1];
            a_mag_o = a_neg ? (~a_i + 1'b1) : a_i;
            b_mag_o = b_neg ? (~b_i + 1'b1) : b_i;
            neg_o   = a_neg ^ b_neg;
         end
      end else begin : g_unsigned
         logic unused_sgn;
         always_comb begin
            unused_sgn = sgn_i;
            a_mag_o    = a_i;
            b_mag_o    = b_i;
            neg_o      = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/mul_iter_core.sv
module mul_iter_core
   import mul_pkg::*;
#(
   parameter int W = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load_i,
   input  logic [W-1:0]   a_mag_i,
   input  logic [W-1:0]   b_mag_i,
   output logic           busy_o,
   output logic           last_o,
   output logic [2*W-1:0] sum_o
);
   localparam int PW    = 2 * W;
   localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(W - 1);

   mul_state_e      state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [PW-1:0]    mcand_q;
   logic [W-1:0]     mplier_q;
   logic [PW-1:0]    prod_q;
   logic [PW-1:0]    addend;

   always_comb begin
      addend = mplier_q[0] ? mcand_q : '0;
      sum_o  = prod_q + addend;
      busy_o = (state_q == ST_RUN);
      last_o = busy_o && (cnt_q == LAST_IDX);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cnt_q    <= '0;
         mcand_q  <= '0;
         mplier_q <= '0;
         prod_q   <= '0;
      end else if (state_q == ST_IDLE) begin
         if (load_i) begin
            state_q  <= ST_RUN;
            cnt_q    <= '0;
            mcand_q  <= {{W{1'b0}}, a_mag_i};
            mplier_q <= b_mag_i;
            prod_q   <= '0;
         end
      end else begin
         prod_q   <= sum_o;
         mcand_q  <= mcand_q << 1;
         mplier_q <= mplier_q >> 1;
         cnt_q    <= cnt_q + 1'b1;
         if (last_o) state_q <= ST_IDLE;
      end
   end

   // R3: a run only ends through its final iteration
   p_run_continues_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !last_o) |=> busy_o);
   // R3: a run starts only from a load request
   p_run_needs_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(load_i));
endmodule

// File: rtl/mul_sign_fix.sv
module mul_sign_fix #(
   parameter int PW        = 64,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic          neg_i,
   input  logic [PW-1:0] val_i,
   output logic [PW-1:0] out_o
);
   generate
      if (SIGNED_EN) begin : g_fix
         always_comb out_o = neg_i ? (~val_i + 1'b1) : val_i;
      end else begin : g_pass
         logic unused_neg;
         always_comb begin
            unused_neg = neg_i;
            out_o      = val_i;
         end
      end
   endgenerate
endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul #(
   parameter int W         = 32,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic         signed_i,
   input  logic [W-1:0] mcand_i,
   input  logic [W-1:0] mplier_i,
   output logic         busy_o,
   output logic         done_o,
   output logic [W-1:0] prod_hi_o,
   output logic [W-1:0] prod_lo_o
);
   localparam int PW = 2 * W;

   initial begin
      assert (W >= 2) else $error("shiftadd_mul: W must be at least 2");
   end

   logic [W-1:0]  a_mag, b_mag;
   logic          neg_now, neg_q;
   logic          load, last;
   logic [PW-1:0] sum, fixed;
   logic [PW-1:0] res_q;
   logic          done_q;

   assign load = start_i && !busy_o;

   mul_operand_mag #(.W(W), .SIGNED_EN(SIGNED_EN)) u_mag (
      .a_i     (mcand_i),
      .b_i     (mplier_i),
      .sgn_i   (signed_i),
      .a_mag_o (a_mag),
      .b_mag_o (b_mag),
      .neg_o   (neg_now)
   );

   mul_iter_core #(.W(W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .a_mag_i (a_mag),
      .b_mag_i (b_mag),
      .busy_o  (busy_o),
      .last_o  (last),
      .sum_o   (sum)
   );

   mul_sign_fix #(.PW(PW), .SIGNED_EN(SIGNED_EN)) u_fix (
      .neg_i (neg_q),
      .val_i (sum),
      .out_o (fixed)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         neg_q  <= 1'b0;
         res_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= last;
         if (load) neg_q <= neg_now;
         if (last) res_q <= fixed;
      end
   end

   assign done_o    = done_q;
   assign prod_hi_o = res_q[PW-1:W];
   assign prod_lo_o = res_q[W-1:0];

   // R4: done lasts one cycle
   p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R4: no iteration in the done cycle
   p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   // R3: done follows a busy cycle
   p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(busy_o));
   // R7: product words hold between completions
   p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(prod_hi_o) && $stable(prod_lo_o)));
   // R5: a start while busy does not restart the run
   p_busy_start_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> (busy_o || done_o));
endmodule

// File: tb/shiftadd_mul_bench.sv
module shiftadd_mul_bench;
   localparam int W  = 32;
   localparam int PW = 2 * W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic         start, sgn;
   logic [W-1:0] a, b;
   logic         busy, done;
   logic [W-1:0] hi, lo;

   logic       s_start;
   logic [3:0] s_a, s_b;
   logic       s_busy, s_done;
   logic [3:0] s_hi, s_lo;

   shiftadd_mul #(.W(W), .SIGNED_EN(1'b1)) u_shiftadd_mul (
      .clk(clk), .rst_n(rst_n), .start_i(start), .signed_i(sgn),
      .mcand_i(a), .mplier_i(b), .busy_o(busy), .done_o(done),
      .prod_hi_o(hi), .prod_lo_o(lo)
   );

   shiftadd_mul #(.W(4), .SIGNED_EN(1'b0)) u_shiftadd_mul_w4 (
      .clk(clk), .rst_n(rst_n), .start_i(s_start), .signed_i(1'b0),
      .mcand_i(s_a), .mplier_i(s_b), .busy_o(s_busy), .done_o(s_done),
      .prod_hi_o(s_hi), .prod_lo_o(s_lo)
   );

   int vectors = 0;
   int errors  = 0;
   int cycles  = 0;
   bit ended   = 1'b0;

   // reference model state
   bit          m_busy, m_done, m_post_rst;
   int          m_cnt;
   logic [PW-1:0] m_res, m_pend;
   string       m_tag, m_pend_tag;

   function automatic logic [PW-1:0] ref_mul(logic [W-1:0] x, logic [W-1:0] y, bit s);
      logic signed [PW-1:0] sx, sy;
      if (s) begin
         sx = {{W{x[W-1]}}, x};
         sy = {{W{y[W-1]}}, y};
         return sx * sy;
      end
      return {{W{1'b0}}, x} * {{W{1'b0}}, y};
   endfunction

   function automatic bit is_corner(logic [W-1:0] v);
      return (v == '0) || (v == W'(1)) || (v == '1);
   endfunction

   task automatic chk(string tag, logic [PW-1:0] act, logic [PW-1:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_cnt = 0; m_res = '0; m_tag = "R1";
         m_post_rst = 1;
      end else begin
         m_post_rst = 0;
         m_done = 0;
         if (m_busy) begin
            m_cnt++;
            if (m_cnt == W) begin
               m_busy = 0; m_done = 1; m_res = m_pend; m_tag = m_pend_tag;
            end
         end else if (start) begin
            m_busy = 1; m_cnt = 0;
            m_pend = ref_mul(a, b, sgn);
            if (is_corner(a) || is_corner(b)) m_pend_tag = "R8";
            else if (sgn) m_pend_tag = "R6";
            else m_pend_tag = "R2";
         end
      end
   end

   always @(negedge clk) begin
      if (!ended) begin
         if (!rst_n || m_post_rst) begin
            chk("R1 busy", PW'(busy), PW'(0));
            chk("R1 done", PW'(done), PW'(0));
            chk("R1 product", {hi, lo}, '0);
         end else begin
            chk("R3/R5 busy", PW'(busy), PW'(m_busy));
            chk("R4 done", PW'(done), PW'(m_done));
            if (m_done) chk(m_tag, {hi, lo}, m_res);
            else        chk("R7 hold", {hi, lo}, m_res);
         end
      end
   end

   // drive at the current negedge, release at the next
   task automatic fire(logic [W-1:0] x, logic [W-1:0] y, bit s);
      a = x; b = y; sgn = s; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      a = $urandom; b = $urandom; sgn = $urandom;
   endtask

   task automatic run_one(logic [W-1:0] x, logic [W-1:0] y, bit s);
      fire(x, y, s);
      repeat (W + 1) @(negedge clk);
   endtask

   task automatic finish_run();
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   endtask

   initial begin
      start = 0; sgn = 0; a = '0; b = '0;
      s_start = 0; s_a = '0; s_b = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: narrow instance, 2 x 3
      s_a = 4'd2; s_b = 4'd3; s_start = 1'b1;
      @(negedge clk);
      s_start = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 not yet done", PW'(s_done), PW'(0));
      @(negedge clk);
      chk("R9 done", PW'(s_done), PW'(1));
      chk("R9 product", PW'({s_hi, s_lo}), PW'(6));
      @(negedge clk);

      // R8: corner operands in both modes
      begin
         logic [W-1:0] cv [3];
         cv[0] = '0; cv[1] = W'(1); cv[2] = '1;
         for (int i = 0; i < 3; i++)
            for (int j = 0; j < 3; j++)
               for (int s = 0; s < 2; s++)
                  run_one(cv[i], cv[j], s[0]);
      end
      // R6: most negative value
      run_one({1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}}, 1'b1);
      run_one({1'b1, {(W-1){1'b0}}}, W'(3), 1'b1);
      run_one(W'(7), -W'(2), 1'b1);

      // R5: start on last iteration ignored, start in done cycle accepted
      for (int k = 0; k < 4; k++) begin
         fire($urandom, $urandom, k[0]);
         repeat (W - 1) @(negedge clk);
         fire($urandom, $urandom, ~k[0]);   // sampled in final iteration
         fire($urandom, $urandom, k[1]);    // sampled in done cycle
         repeat (W / 2) @(negedge clk);
         fire($urandom, $urandom, 1'b0);    // mid-run, ignored
         repeat (W) @(negedge clk);
      end

      // R2/R6: random pairs with random gaps
      for (int n = 0; n < 60; n++) begin
         fire($urandom, $urandom, n[0]);
         repeat (W - 1 + ($urandom % 4)) @(negedge clk);
      end
      repeat (W + 4) @(negedge clk);
      finish_run();
   end

   initial begin
      wait (cycles > 150000);
      vectors++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
   end
endmodule